// File: doc/BRIEF.md
# DMA Protected Range Guard

This block sits on the inbound DMA path and decides, for each request, whether the target address lies inside a protected window. There are two windows. The first is a 32-bit window that only covers the space below 4 GiB. The second is a window that spans the full host address width. Software programs each window as an inclusive pair: a base, and a limit equal to base plus length minus one. When protection is active, the block answers every valid request with allow or block.

Software reaches the block over a simple word-addressed 64-bit register bus. A capability register reports that both windows are supported. Window registers tie their low-order bits to a fixed value, so their granularity can be discovered by writing all ones, reading back, and taking the two's complement. Turning protection on or off is a two-step sequence: software writes a request bit, then polls a status bit. The status bit only follows the request after a fixed delay.

Top module: `dma_range_guard`

## Requirements
- R1: The capability register (word 0) reads 64'h3: bit 0 flags low-window support, bit 1 flags high-window support, and every other bit is zero.
- R2: The control register (word 1) reads the last written bit 31 back in bit 31 and the protection status in bit 0, with every other bit zero. Both bits are 0 after reset.
- R3: The status bit takes the requested value exactly EN_DELAY clock edges after the write that changed the request. A write that returns the request to the current status before that happens cancels the change.
- R4: The low base (word 2) reads zero in bits below LOW_ALIGN and in bits 63:32, and resets to all ones in bits 31:LOW_ALIGN. Writes to the tied bits are ignored, so two's complement of the low 32 bits after an all-ones write equals 2^LOW_ALIGN.
- R5: The high base (word 4) reads ones in bits ADDR_W and above, reads zero below HIGH_ALIGN, and resets to all ones in its writable bits. The all-ones readback, negated and masked to ADDR_W bits, equals 2^HIGH_ALIGN.
- R6: The limit registers (low at word 3, high at word 5) read ones in the bits below their window's alignment. The low limit reads zero in bits 63:32 and the high limit reads ones in bits ADDR_W and above. Their writable bits reset to zero.
- R7: While status is on, a request with address below 2^32 and low base ≤ address ≤ low limit is blocked.
- R8: While status is on, a request with high base ≤ address ≤ high limit is blocked, for any address below 2^ADDR_W.
- R9: While status is off, every request is allowed, whatever the windows hold and whatever the pending request bit is.
- R10: A window whose base and limit writable bits are all ones is empty. It matches only the single topmost address of its span (2^32−1 for low, 2^ADDR_W−1 for high).
- R11: The response valid and verdict appear on the clock edge after a request is sampled. With no request, both are low one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word select |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for regAddr, combinational |
| dmaValid | input | 1 | DMA request present |
| dmaAddr | input | ADDR_W | DMA request address |
| dmaRespValid | output | 1 | Verdict present, one edge after dmaValid |
| dmaBlock | output | 1 | 1 = block, 0 = allow |

## Verification
Register reads are combinational, so the bench samples them in the same half cycle in which it sets the word select. A DMA verdict is registered once, so the bench raises a request at a falling edge and reads the response at the next falling edge, after one rising edge. The status bit is due EN_DELAY rising edges after the write edge. The bench polls once per cycle and counts edges against that figure. A request issued in the cycle after a disable write must still see the old status. Each probe is compared with a window model the bench computes from the values it programmed, swept around every base, limit and the 4 GiB boundary.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam logic [2:0] REG_CAP     = 3'd0;
  localparam logic [2:0] REG_CTRL    = 3'd1;
  localparam logic [2:0] REG_LO_BASE = 3'd2;
  localparam logic [2:0] REG_LO_LIM  = 3'd3;
  localparam logic [2:0] REG_HI_BASE = 3'd4;
  localparam logic [2:0] REG_HI_LIM  = 3'd5;

  typedef struct packed {
    logic wrLowBase;
    logic wrLowLimit;
    logic wrHighBase;
    logic wrHighLimit;
  } regStrobe_t;
endpackage

// File: rtl/dma_guard_ctrl.sv
module dma_guard_ctrl
  import dma_guard_pkg::*;
#(
  parameter int EN_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic       wrReqBit,
  output regStrobe_t strobe,
  output logic       reqOn,
  output logic       statusOn
);
  localparam int CNT_W = $clog2(EN_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EN_DELAY - 1);

  logic [CNT_W-1:0] delayCnt;
  logic             reqQ;
  logic             statQ;
  logic             ctrlWr;

  always_comb begin
    ctrlWr             = regWrEn && (regAddr == REG_CTRL);
    strobe.wrLowBase   = regWrEn && (regAddr == REG_LO_BASE);
    strobe.wrLowLimit  = regWrEn && (regAddr == REG_LO_LIM);
    strobe.wrHighBase  = regWrEn && (regAddr == REG_HI_BASE);
    strobe.wrHighLimit = regWrEn && (regAddr == REG_HI_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ     <= 1'b0;
      statQ    <= 1'b0;
      delayCnt <= '0;
    end else begin
      if (ctrlWr) reqQ <= wrReqBit;
      if (ctrlWr && (wrReqBit != reqQ)) begin
        delayCnt <= '0;
      end else if (reqQ != statQ) begin
        if (delayCnt == CNT_LAST) begin
          statQ    <= reqQ;
          delayCnt <= '0;
        end else begin
          delayCnt <= delayCnt + 1'b1;
        end
      end else begin
        delayCnt <= '0;
      end
    end
  end

  assign reqOn    = reqQ;
  assign statusOn = statQ;
endmodule

// File: rtl/dma_guard_range.sv
module dma_guard_range #(
  parameter int W     = 32,
  parameter int ALIGN = 21
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrBase,
  input  logic         wrLimit,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] addr,
  output logic [W-1:0] baseRd,
  output logic [W-1:0] limitRd,
  output logic         hit
);
  localparam int HI_W = W - ALIGN;

  logic [HI_W-1:0] baseQ;
  logic [HI_W-1:0] limitQ;
  logic [W-1:0]    baseEff;
  logic [W-1:0]    limitEff;
  logic            emptyWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '1;
      limitQ <= '0;
    end else begin
      if (wrBase)  baseQ  <= wrData[W-1:ALIGN];
      if (wrLimit) limitQ <= wrData[W-1:ALIGN];
    end
  end

  always_comb begin
    emptyWin = (&baseQ) && (&limitQ);
    baseEff  = emptyWin ? '1 : {baseQ, {ALIGN{1'b0}}};
    limitEff = {limitQ, {ALIGN{1'b1}}};
    hit      = (addr >= baseEff) && (addr <= limitEff);
    baseRd   = {baseQ, {ALIGN{1'b0}}};
    limitRd  = limitEff;
  end
endmodule

// File: rtl/dma_guard_datapath.sv
module dma_guard_datapath
  import dma_guard_pkg::*;
#(
  parameter int ADDR_W     = 39,
  parameter int LOW_ALIGN  = 21,
  parameter int HIGH_ALIGN = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              statusOn,
  input  logic              dmaValid,
  input  logic [ADDR_W-1:0] dmaAddr,
  output logic [63:0]       lowBaseRd,
  output logic [63:0]       lowLimitRd,
  output logic [63:0]       highBaseRd,
  output logic [63:0]       highLimitRd,
  output logic              respValid,
  output logic              respBlock
);
  localparam int LOW_W = 32;
  localparam int PAD_W = 64 - ADDR_W;

  logic [LOW_W-1:0]  loBase, loLimit;
  logic [ADDR_W-1:0] hiBase, hiLimit;
  logic              loHit, hiHit, below4g, anyHit;

  dma_guard_range #(.W(LOW_W), .ALIGN(LOW_ALIGN)) lowWin_i (
    .clk(clk), .rstN(rstN),
    .wrBase(strobe.wrLowBase), .wrLimit(strobe.wrLowLimit),
    .wrData(wrData[LOW_W-1:0]), .addr(dmaAddr[LOW_W-1:0]),
    .baseRd(loBase), .limitRd(loLimit), .hit(loHit)
  );

  dma_guard_range #(.W(ADDR_W), .ALIGN(HIGH_ALIGN)) highWin_i (
    .clk(clk), .rstN(rstN),
    .wrBase(strobe.wrHighBase), .wrLimit(strobe.wrHighLimit),
    .wrData(wrData), .addr(dmaAddr),
    .baseRd(hiBase), .limitRd(hiLimit), .hit(hiHit)
  );

  always_comb begin
    below4g     = ~|dmaAddr[ADDR_W-1:LOW_W];
    anyHit      = (loHit && below4g) || hiHit;
    lowBaseRd   = {32'b0, loBase};
    lowLimitRd  = {32'b0, loLimit};
    highBaseRd  = {{PAD_W{1'b1}}, hiBase};
    highLimitRd = {{PAD_W{1'b1}}, hiLimit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respBlock <= 1'b0;
    end else begin
      respValid <= dmaValid;
      respBlock <= dmaValid && statusOn && anyHit;
    end
  end
endmodule

// File: rtl/dma_range_guard.sv
module dma_range_guard
  import dma_guard_pkg::*;
#(
  parameter int ADDR_W     = 39,
  parameter int LOW_ALIGN  = 21,
  parameter int HIGH_ALIGN = 21,
  parameter int EN_DELAY   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              dmaValid,
  input  logic [ADDR_W-1:0] dmaAddr,
  output logic              dmaRespValid,
  output logic              dmaBlock
);
  regStrobe_t  strobe;
  logic        reqOn, statusOn;
  logic [63:0] lowBaseRd, lowLimitRd, highBaseRd, highLimitRd;
  logic        unusedWrBits;

  assign unusedWrBits = ^regWrData[63:ADDR_W];

  dma_guard_ctrl #(.EN_DELAY(EN_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrReqBit(regWrData[31]), .strobe(strobe),
    .reqOn(reqOn), .statusOn(statusOn)
  );

  dma_guard_datapath #(
    .ADDR_W(ADDR_W), .LOW_ALIGN(LOW_ALIGN), .HIGH_ALIGN(HIGH_ALIGN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(regWrData[ADDR_W-1:0]), .statusOn(statusOn),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr),
    .lowBaseRd(lowBaseRd), .lowLimitRd(lowLimitRd),
    .highBaseRd(highBaseRd), .highLimitRd(highLimitRd),
    .respValid(dmaRespValid), .respBlock(dmaBlock)
  );

  always_comb begin
    case (regAddr)
      REG_CAP:     regRdData = 64'h3;
      REG_CTRL:    regRdData = {32'b0, reqOn, 30'b0, statusOn};
      REG_LO_BASE: regRdData = lowBaseRd;
      REG_LO_LIM:  regRdData = lowLimitRd;
      REG_HI_BASE: regRdData = highBaseRd;
      REG_HI_LIM:  regRdData = highLimitRd;
      default:     regRdData = 64'b0;
    endcase
  end
endmodule

// File: rtl/dma_range_guard_chk.sv
module dma_range_guard_chk
  import dma_guard_pkg::*;
#(
  parameter int ADDR_W    = 39,
  parameter int LOW_ALIGN = 21
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic        wrReqBit,
  input logic [63:0] regRdData,
  input logic        dmaValid,
  input logic        dmaRespValid,
  input logic        dmaBlock,
  input logic        reqOn,
  input logic        statusOn
);
  AST_CAP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_CAP) |-> (regRdData == 64'h3)); // R1

  AST_STATUS_TAKES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOn) |-> (statusOn == $past(reqOn))); // R3

  AST_STATUS_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_CTRL && wrReqBit != statusOn && wrReqBit != reqOn)
    |=> $stable(statusOn)); // R3

  AST_LOW_BASE_TIED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_LO_BASE) |->
      (regRdData[LOW_ALIGN-1:0] == '0 && regRdData[63:32] == 32'b0)); // R4

  AST_HIGH_BASE_TOP_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_HI_BASE) |-> (&regRdData[63:ADDR_W])); // R5

  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && !statusOn) |=> !dmaBlock); // R9

  AST_RESP_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |=> dmaRespValid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dmaValid |=> (!dmaRespValid && !dmaBlock)); // R11
endmodule

bind dma_range_guard dma_range_guard_chk #(.ADDR_W(ADDR_W), .LOW_ALIGN(LOW_ALIGN)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrReqBit(regWrData[31]), .regRdData(regRdData), .dmaValid(dmaValid),
  .dmaRespValid(dmaRespValid), .dmaBlock(dmaBlock),
  .reqOn(reqOn), .statusOn(statusOn)
);

// File: tb/dma_range_guard_tb_top.sv
`timescale 1ns/1ps
module dma_range_guard_tb_top;
  localparam int AW = 36;
  localparam int LA = 12;
  localparam int HA = 16;
  localparam int ED = 3;
  localparam logic [63:0] AMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [63:0]   regWrData = '0;
  logic [63:0]   regRdData;
  logic          dmaValid = 1'b0;
  logic [AW-1:0] dmaAddr = '0;
  logic          dmaRespValid, dmaBlock;

  dma_range_guard #(.ADDR_W(AW), .LOW_ALIGN(LA), .HIGH_ALIGN(HA), .EN_DELAY(ED)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaValid(dmaValid),
    .dmaAddr(dmaAddr), .dmaRespValid(dmaRespValid), .dmaBlock(dmaBlock)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit protOn = 1'b0;
  logic [63:0] loLo, loHi, hiLo, hiHi;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(logic [2:0] a, output logic [63:0] d);
    regAddr = a;
    #0.1;
    d = regRdData;
  endtask

  function automatic logic expBlk(logic [63:0] a);
    return protOn && ((a < 64'h1_0000_0000 && a >= loLo && a <= loHi) ||
                      (a >= hiLo && a <= hiHi));
  endfunction

  task automatic probe(logic [63:0] aIn, string req);
    logic [63:0] a;
    a = aIn & AMASK;
    @(negedge clk);
    dmaValid = 1'b1; dmaAddr = a[AW-1:0];
    @(negedge clk);
    dmaValid = 1'b0;
    check({req, " respValid"}, {63'b0, dmaRespValid}, 64'd1);
    check(req, {63'b0, dmaBlock}, {63'b0, expBlk(a)});
  endtask

  task automatic sweep(string lowReq, string highReq);
    for (int k = -1; k <= 1; k++) begin
      probe(loLo + 64'(k), lowReq);
      probe(loHi + 64'(k), lowReq);
      probe(64'h1_0000_0000 + loLo + 64'(k), lowReq);
      probe(hiLo + 64'(k), highReq);
      probe(hiHi + 64'(k), highReq);
    end
    probe(64'hFFFF_FFFF, lowReq);
    probe(64'h1_0000_0000, lowReq);
    for (int i = 0; i < 32; i++)
      probe(64'(i) * (64'd1 << (AW - 5)) + 64'h1_2345, highReq);
  endtask

  task automatic pollStatus(logic expv, output int cycles);
    logic [63:0] d;
    cycles = 0;
    regRd(dma_guard_pkg::REG_CTRL, d);
    while (d[0] != expv && cycles < 40) begin
      @(negedge clk);
      cycles++;
      regRd(dma_guard_pkg::REG_CTRL, d);
    end
  endtask

  task automatic useNormalWindows();
    regWr(dma_guard_pkg::REG_LO_BASE, 64'h0010_0000);
    regWr(dma_guard_pkg::REG_LO_LIM,  64'h0012_FFFF);
    regWr(dma_guard_pkg::REG_HI_BASE, 64'h8_0000_0000);
    regWr(dma_guard_pkg::REG_HI_LIM,  64'h8_0001_FFFF);
    loLo = 64'h0010_0000;   loHi = 64'h0012_FFFF;
    hiLo = 64'h8_0000_0000; hiHi = 64'h8_0001_FFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset values
    regRd(dma_guard_pkg::REG_CAP, d);     check("R1 capability", d, 64'h3);
    regRd(dma_guard_pkg::REG_CTRL, d);    check("R2 control reset", d, 64'h0);
    regRd(dma_guard_pkg::REG_LO_BASE, d); check("R4 low base reset", d, 64'h0000_0000_FFFF_F000);
    regRd(dma_guard_pkg::REG_HI_BASE, d); check("R5 high base reset", d, 64'hFFFF_FFFF_FFFF_0000);
    regRd(dma_guard_pkg::REG_LO_LIM, d);  check("R6 low limit reset", d, 64'h0000_0000_0000_0FFF);
    regRd(dma_guard_pkg::REG_HI_LIM, d);  check("R6 high limit reset", d, 64'hFFFF_FFF0_0000_FFFF);

    // granularity discovery
    regWr(dma_guard_pkg::REG_LO_BASE, '1);
    regRd(dma_guard_pkg::REG_LO_BASE, d);
    check("R4 low granularity", {32'b0, ~d[31:0] + 32'd1}, 64'h1000);
    regWr(dma_guard_pkg::REG_HI_BASE, '1);
    regRd(dma_guard_pkg::REG_HI_BASE, d);
    check("R5 high granularity", (~d + 64'd1) & AMASK, 64'h1_0000);

    // tied bits ignore writes
    regWr(dma_guard_pkg::REG_LO_BASE, 64'hFFFF_FFFF_0010_0ABC);
    regRd(dma_guard_pkg::REG_LO_BASE, d); check("R4 tied bits ignored", d, 64'h0010_0000);

    useNormalWindows();
    regRd(dma_guard_pkg::REG_LO_LIM, d);  check("R6 low limit readback", d, 64'h0012_FFFF);
    regRd(dma_guard_pkg::REG_HI_BASE, d); check("R5 high base readback", d, 64'hFFFF_FFF8_0000_0000);
    regRd(dma_guard_pkg::REG_HI_LIM, d);  check("R6 high limit readback", d, 64'hFFFF_FFF8_0001_FFFF);

    // protection off
    protOn = 1'b0;
    sweep("R9 off low", "R9 off high");

    // enable, count poll cycles
    regWr(dma_guard_pkg::REG_CTRL, 64'h8000_0000);
    regRd(dma_guard_pkg::REG_CTRL, d); check("R2 request pending", d, 64'h8000_0000);
    pollStatus(1'b1, cyc);
    check("R3 enable delay", 64'(cyc), 64'(ED));
    regRd(dma_guard_pkg::REG_CTRL, d); check("R2 enabled readback", d, 64'h8000_0001);
    protOn = 1'b1;
    sweep("R7", "R8");

    // empty windows
    regWr(dma_guard_pkg::REG_LO_BASE, 64'hFFFF_FFFF);
    regWr(dma_guard_pkg::REG_LO_LIM,  64'hFFFF_FFFE);
    regWr(dma_guard_pkg::REG_HI_BASE, 64'hFFFF_FFFF_FFFF_FFFF);
    regWr(dma_guard_pkg::REG_HI_LIM,  64'hFFFF_FFFF_FFFF_FFFE);
    loLo = 64'hFFFF_FFFF; loHi = 64'hFFFF_FFFF;
    hiLo = AMASK;         hiHi = AMASK;
    sweep("R10 low", "R10 high");
    probe(64'hFFFF_F000, "R10 low top granule");
    probe(AMASK - 64'h1_0000 + 1, "R10 high top granule");

    // disable with poll count
    useNormalWindows();
    regWr(dma_guard_pkg::REG_CTRL, 64'h0);
    pollStatus(1'b0, cyc);
    check("R3 disable delay", 64'(cyc), 64'(ED));
    protOn = 1'b0;
    sweep("R9 after disable", "R9 after disable");

    // re-enable, then disable: status lags request
    regWr(dma_guard_pkg::REG_CTRL, 64'h8000_0000);
    pollStatus(1'b1, cyc);
    regWr(dma_guard_pkg::REG_CTRL, 64'h0);
    protOn = 1'b1;
    probe(64'h0011_0000, "R3 status lag");
    repeat (ED) @(negedge clk);
    protOn = 1'b0;
    probe(64'h0011_0000, "R9 settled off");

    // cancelled request
    regWr(dma_guard_pkg::REG_CTRL, 64'h8000_0000);
    regWr(dma_guard_pkg::REG_CTRL, 64'h0);
    repeat (3 * ED + 4) @(negedge clk);
    regRd(dma_guard_pkg::REG_CTRL, d); check("R3 cancelled request", d, 64'h0);

    // idle response
    @(negedge clk);
    check("R11 idle respValid", {63'b0, dmaRespValid}, 64'd0);
    check("R11 idle block", {63'b0, dmaBlock}, 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule